// File: doc/BRIEF.md
# DDR2 Command Latency Scheduler

This block sits between a memory controller's request logic and the command path to a four-bank DDR2 memory. It decides, one request per cycle, whether an ACTIVATE, READ, WRITE or PRECHARGE may be issued now. Each bank keeps its own row-open state and its own timers. A request that is not yet legal stays on the inputs and its grant stays low until the constraint is met. The grant is combinational from the request and registered timer state, so a held request is granted in the first legal cycle.

The scheduler also tells the data path when each burst occupies the bus. Read latency is the programmed additive latency plus CAS latency. Write latency is one cycle less than read latency. A burst of 4 or 8 beats moves on both clock edges, so it holds the bus for half its beat count in clock cycles. A column command may carry an auto-precharge flag. The bank then closes by itself at the point where an explicit precharge would first have been legal, and the precharge delay starts from there.

Top module: `ddr2_cmd_sched`

## Requirements
- R1: An ACTIVATE (req_cmd 0) to a bank is granted only when that bank is idle and at least T_RP (default 5) cycles have passed since its last precharge. An ACTIVATE to an open bank is held.
- R2: A READ (req_cmd 1) or WRITE (req_cmd 2) is granted only to an open bank, and no earlier than max(T_RCD − AL, 1) cycles after that bank's ACTIVATE grant (T_RCD default 5). A column command to an idle bank is held.
- R3: Two column commands are at least BL/2 cycles apart, or BL/2 + 1 cycles when a READ is followed by a WRITE. BL is 4 when cfg_bl8 is 0 and 8 when it is 1. Read and write windows never overlap.
- R4: For a READ granted in cycle t, rd_valid is high in exactly the BL/2 consecutive cycles starting at t + AL + CL.
- R5: For a WRITE granted in cycle t, wr_valid is high in exactly the BL/2 consecutive cycles starting at t + AL + CL − 1.
- R6: An explicit PRECHARGE (req_cmd 3) to an open bank is granted no earlier than AL + BL/2 cycles after the last column command to it. The bank is then idle.
- R7: A column command with req_ap high closes its bank automatically AL + BL/2 cycles after its grant. Until then, column and precharge requests to that bank are held. The next ACTIVATE to it is legal T_RP cycles after the close.
- R8: A PRECHARGE to an idle bank is granted at once and has no effect. In particular, it does not restart that bank's precharge delay.
- R9: Banks are independent: an ACTIVATE to an idle bank is granted while other banks are open. A bank stays open until it receives a PRECHARGE or an automatic close.
- R10: grant is high only while req_valid is high. After reset all banks are idle and rd_valid and wr_valid are low. AL is valid from 0 to 6 and CL from 2 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| req_bank | input | 2 | Target bank |
| req_ap | input | 1 | Auto precharge after this column command |
| cfg_al | input | 3 | Additive latency in cycles (0 to 6) |
| cfg_cl | input | 3 | CAS latency in cycles (2 to 7) |
| cfg_bl8 | input | 1 | 0: burst of 4 beats, 1: burst of 8 beats |
| grant | output | 1 | The request is legal and is issued this cycle |
| rd_valid | output | 1 | Read data occupies the bus this cycle |
| wr_valid | output | 1 | Write data must be driven this cycle |

## Verification
The hardest case to reach from the ports is a request that several timers gate at once. One example is a WRITE that follows a READ, where both the ACTIVATE-to-column delay and the read-to-write turnaround apply. Another is a bank whose auto-precharge close is pending while a new ACTIVATE waits behind it. The bench holds each request from the cycle after the previous grant, so every grant lands on its earliest legal cycle. It sweeps all additive latencies, CAS latencies 3 to 6 and both burst lengths, and compares each grant cycle and each data-window edge with values computed from the configuration.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // clock cycles a burst holds the data bus (two beats per cycle)
  function automatic int unsigned beat_cycles(input logic bl8);
    return bl8 ? 32'd4 : 32'd2;
  endfunction

  // cycles from ACTIVATE to the first legal column command, with posted CAS
  function automatic int unsigned act_to_col(input int unsigned trcd, input int unsigned al);
    return (trcd > al + 1) ? (trcd - al) : 32'd1;
  endfunction

  // cycles from a column command to the first legal precharge of its bank
  function automatic int unsigned col_to_pre(input int unsigned al, input logic bl8);
    return al + beat_cycles(bl8);
  endfunction

endpackage

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer
  import ddr2_sched_pkg::*;
#(
  parameter int T_RCD = 5,
  parameter int T_RP  = 5,
  parameter int AL_W  = 3,
  parameter int TW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_go,
  input  logic            col_go,
  input  logic            col_ap,
  input  logic            pre_go,
  input  logic [AL_W-1:0] al,
  input  logic            bl8,
  output logic            is_open,
  output logic            act_ok,
  output logic            col_ok,
  output logic            pre_ok,
  output logic            ap_close
);

  logic          open_q;
  logic          ap_q;
  logic [TW-1:0] rcd_q;
  logic [TW-1:0] c2p_q;
  logic [TW-1:0] rp_q;
  logic [TW-1:0] rcd_load;
  logic [TW-1:0] c2p_load;
  logic          close_now;

  assign rcd_load  = TW'(act_to_col(T_RCD, 32'(al)) - 1);
  assign c2p_load  = TW'(col_to_pre(32'(al), bl8) - 1);

  assign is_open   = open_q;
  assign act_ok    = !open_q && (rp_q == '0);
  assign col_ok    = open_q && !ap_q && (rcd_q == '0);
  assign pre_ok    = !open_q || (!ap_q && (c2p_q == '0));
  assign ap_close  = open_q && ap_q && (c2p_q == '0);
  assign close_now = (pre_go && open_q) || ap_close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      rcd_q  <= '0;
      c2p_q  <= '0;
      rp_q   <= '0;
    end else begin
      if (act_go) begin
        open_q <= 1'b1;
        rcd_q  <= rcd_load;
      end else if (rcd_q != '0) begin
        rcd_q <= rcd_q - 1'b1;
      end

      if (col_go) begin
        c2p_q <= c2p_load;
        ap_q  <= col_ap;
      end else if (c2p_q != '0) begin
        c2p_q <= c2p_q - 1'b1;
      end

      if (close_now) begin
        open_q <= 1'b0;
        ap_q   <= 1'b0;
        rp_q   <= TW'(T_RP - 1);
      end else if (rp_q != '0) begin
        rp_q <= rp_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr2_bus_guard.sv
module ddr2_bus_guard
  import ddr2_sched_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_go,
  input  logic col_is_rd,
  input  logic want_wr,
  input  logic bl8,
  output logic bus_ok
);

  logic [GAP_W-1:0] gap_q;
  logic             last_rd_q;
  int unsigned      need;

  always_comb begin
    need   = beat_cycles(bl8) + ((last_rd_q && want_wr) ? 32'd1 : 32'd0);
    bus_ok = 32'(gap_q) >= need;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q     <= '1;
      last_rd_q <= 1'b0;
    end else if (col_go) begin
      gap_q     <= GAP_W'(1);
      last_rd_q <= col_is_rd;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

endmodule

// File: rtl/ddr2_data_window.sv
module ddr2_data_window
  import ddr2_sched_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int WIN   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LAT_W-1:0] lat,
  input  logic             bl8,
  output logic             valid
);

  logic [WIN-1:0] slots_q;
  logic [WIN-1:0] span;

  // bit i of the mask stands for the cycle i+1 after the launch cycle
  function automatic logic [WIN-1:0] span_mask(input logic [LAT_W-1:0] l, input logic b8);
    logic [WIN-1:0] m;
    int lo;
    int hi;
    lo = int'(l);
    hi = lo + int'(beat_cycles(b8));
    for (int i = 0; i < WIN; i++) begin
      m[i] = ((i + 1) >= lo) && ((i + 1) < hi);
    end
    return m;
  endfunction

  assign span  = span_mask(lat, bl8);
  assign valid = slots_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots_q <= '0;
    end else begin
      slots_q <= (slots_q >> 1) | (launch ? span : '0);
    end
  end

endmodule

// File: rtl/ddr2_cmd_sched.sv
module ddr2_cmd_sched
  import ddr2_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 5,
  parameter int T_RP      = 5,
  parameter int AL_W      = 3,
  parameter int CL_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [1:0]                   req_cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic                         req_ap,
  input  logic [AL_W-1:0]              cfg_al,
  input  logic [CL_W-1:0]              cfg_cl,
  input  logic                         cfg_bl8,
  output logic                         grant,
  output logic                         rd_valid,
  output logic                         wr_valid
);

  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int LAT_W   = ((AL_W > CL_W) ? AL_W : CL_W) + 1;
  localparam int MAX_AL  = (1 << AL_W) - 1;
  localparam int MAX_LAT = MAX_AL + (1 << CL_W) - 1;
  localparam int WIN     = MAX_LAT + 4;
  localparam int TMAX0   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TMAX    = (TMAX0 > MAX_AL + 4) ? TMAX0 : MAX_AL + 4;
  localparam int TW      = $clog2(TMAX + 1);

  cmd_e                 cmd_s;
  logic                 is_col;
  logic                 legal;
  logic [NUM_BANKS-1:0] bank_open;
  logic [NUM_BANKS-1:0] act_ok;
  logic [NUM_BANKS-1:0] col_ok;
  logic [NUM_BANKS-1:0] pre_ok;
  logic [NUM_BANKS-1:0] ap_close;
  logic [NUM_BANKS-1:0] act_go;
  logic [NUM_BANKS-1:0] col_go;
  logic [NUM_BANKS-1:0] pre_go;
  logic                 bus_ok;
  logic                 col_grant;
  logic                 rd_launch;
  logic                 wr_launch;
  logic [LAT_W-1:0]     rd_lat;
  logic [LAT_W-1:0]     wr_lat;

  assign cmd_s  = cmd_e'(req_cmd);
  assign is_col = (cmd_s == CMD_RD) || (cmd_s == CMD_WR);

  always_comb begin
    case (cmd_s)
      CMD_ACT: legal = act_ok[req_bank];
      CMD_RD,
      CMD_WR:  legal = col_ok[req_bank] && bus_ok;
      default: legal = pre_ok[req_bank];
    endcase
  end

  assign grant     = req_valid && legal;
  assign col_grant = grant && is_col;
  assign rd_launch = grant && (cmd_s == CMD_RD);
  assign wr_launch = grant && (cmd_s == CMD_WR);
  assign rd_lat    = LAT_W'(cfg_al) + LAT_W'(cfg_cl);
  assign wr_lat    = rd_lat - 1'b1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit       = grant && (req_bank == BANK_W'(b));
    assign act_go[b] = hit && (cmd_s == CMD_ACT);
    assign col_go[b] = hit && is_col;
    assign pre_go[b] = hit && (cmd_s == CMD_PRE);

    ddr2_bank_timer #(
      .T_RCD (T_RCD),
      .T_RP  (T_RP),
      .AL_W  (AL_W),
      .TW    (TW)
    ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_go   (act_go[b]),
      .col_go   (col_go[b]),
      .col_ap   (req_ap),
      .pre_go   (pre_go[b]),
      .al       (cfg_al),
      .bl8      (cfg_bl8),
      .is_open  (bank_open[b]),
      .act_ok   (act_ok[b]),
      .col_ok   (col_ok[b]),
      .pre_ok   (pre_ok[b]),
      .ap_close (ap_close[b])
    );
  end

  ddr2_bus_guard #(
    .GAP_W (4)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_go    (col_grant),
    .col_is_rd (cmd_s == CMD_RD),
    .want_wr   (cmd_s == CMD_WR),
    .bl8       (cfg_bl8),
    .bus_ok    (bus_ok)
  );

  ddr2_data_window #(
    .LAT_W (LAT_W),
    .WIN   (WIN)
  ) u_rd_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (rd_launch),
    .lat    (rd_lat),
    .bl8    (cfg_bl8),
    .valid  (rd_valid)
  );

  ddr2_data_window #(
    .LAT_W (LAT_W),
    .WIN   (WIN)
  ) u_wr_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (wr_launch),
    .lat    (wr_lat),
    .bl8    (cfg_bl8),
    .valid  (wr_valid)
  );

endmodule

// File: rtl/ddr2_sched_chk.sv
module ddr2_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [1:0]           req_cmd,
  input logic [BANK_W-1:0]    req_bank,
  input logic                 grant,
  input logic                 rd_valid,
  input logic                 wr_valid,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] ap_close
);

  a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid);

  a_r3_bus_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  a_r1_act_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_cmd == 2'd0) |-> !bank_open[req_bank]);

  a_r1_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_cmd == 2'd0) |=> bank_open[$past(req_bank)]);

  a_r2_col_to_open: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (req_cmd == 2'd1 || req_cmd == 2'd2)) |-> bank_open[req_bank]);

  a_r8_idle_pre_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_cmd == 2'd3 && !bank_open[req_bank]) |=> !bank_open[$past(req_bank)]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    a_r7_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
      ap_close[b] |=> !bank_open[b]);

    a_r9_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_open[b] && !ap_close[b] &&
       !(grant && req_cmd == 2'd3 && req_bank == BANK_W'(b))) |=> bank_open[b]);
  end

endmodule

bind ddr2_cmd_sched ddr2_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .req_bank  (req_bank),
  .grant     (grant),
  .rd_valid  (rd_valid),
  .wr_valid  (wr_valid),
  .bank_open (bank_open),
  .ap_close  (ap_close)
);

// File: tb/test_ddr2_cmd_sched.sv
module test_ddr2_cmd_sched;

  localparam logic [1:0] C_ACT = 2'd0;
  localparam logic [1:0] C_RD  = 2'd1;
  localparam logic [1:0] C_WR  = 2'd2;
  localparam logic [1:0] C_PRE = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_cmd;
  logic [1:0] req_bank;
  logic       req_ap;
  logic [2:0] cfg_al;
  logic [2:0] cfg_cl;
  logic       cfg_bl8;
  logic       grant;
  logic       rd_valid;
  logic       wr_valid;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int rd_first, rd_last, rd_cnt;
  int wr_first, wr_last, wr_cnt;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_cmd_sched i_ddr2_cmd_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_bank  (req_bank),
    .req_ap    (req_ap),
    .cfg_al    (cfg_al),
    .cfg_cl    (cfg_cl),
    .cfg_bl8   (cfg_bl8),
    .grant     (grant),
    .rd_valid  (rd_valid),
    .wr_valid  (wr_valid)
  );

  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_cnt == 0) rd_first = cyc;
      rd_last = cyc;
      rd_cnt++;
    end
    if (wr_valid) begin
      if (wr_cnt == 0) wr_first = cyc;
      wr_last = cyc;
      wr_cnt++;
    end
  end

  task automatic clear_windows();
    rd_first = 0; rd_last = 0; rd_cnt = 0;
    wr_first = 0; wr_last = 0; wr_cnt = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // hold a request until granted; s = first requesting cycle, g = grant cycle
  task automatic issue(input string tag, input logic [1:0] c, input logic [1:0] b,
                       input logic ap, output int s, output int g);
    int loops = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = b; req_ap = ap;
    s = cyc;
    #1;
    while (!grant && loops < 300) begin
      @(negedge clk);
      #1;
      loops++;
    end
    g = cyc;
    if (!grant) begin
      n_tests++;
      n_fail++;
      $display("FAIL %s: actual no grant expected grant", tag);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_ap = 1'b0;
  endtask

  // present a request for n cycles and check it is never granted
  task automatic expect_hold(input string tag, input logic [1:0] c, input logic [1:0] b, input int n);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = b; req_ap = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk(tag, int'(grant), 0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R10: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int s, g, ga, grd, gwr, gpre, gact, beats, eff, rl;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = C_ACT; req_bank = 2'd0; req_ap = 1'b0;
    cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0;
    clear_windows();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state and no grant without req_valid
    chk("R10 rd_valid after reset", int'(rd_valid), 0);
    chk("R10 wr_valid after reset", int'(wr_valid), 0);
    chk("R10 no grant without req_valid", int'(grant), 0);

    // R2: column command to an idle bank is held
    expect_hold("R2 read to idle bank held", C_RD, 2'd0, 3);

    // R8: precharge to idle bank granted at once, no delay restart
    issue("R8 idle precharge", C_PRE, 2'd2, 1'b0, s, g);
    chk("R8 idle precharge immediate", g, s);
    issue("R8 activate after idle precharge", C_ACT, 2'd2, 1'b0, s, g);
    chk("R8 activate not delayed", g, s);
    ga = g;
    issue("R6 precharge without column", C_PRE, 2'd2, 1'b0, s, g);
    chk("R6 precharge right after activate", g, ga + 1);
    gpre = g;
    issue("R1 activate after precharge", C_ACT, 2'd2, 1'b0, s, g);
    chk("R1 activate waits precharge delay", g, gpre + 5);
    issue("R6 close bank 2", C_PRE, 2'd2, 1'b0, s, g);
    repeat (10) @(negedge clk);

    // R9 and R3 with burst of 8, AL 0, CL 3
    cfg_bl8 = 1'b1;
    issue("R1 activate bank 0", C_ACT, 2'd0, 1'b0, s, ga);
    expect_hold("R1 activate to open bank held", C_ACT, 2'd0, 2);
    issue("R9 activate bank 3", C_ACT, 2'd3, 1'b0, s, g);
    chk("R9 second bank activate immediate", g, s);
    issue("R2 read bank 0", C_RD, 2'd0, 1'b0, s, g);
    chk("R2 read after activate delay", g, ga + 5);
    issue("R3 read bank 3", C_RD, 2'd3, 1'b0, s, g);
    chk("R3 read to read spacing", g, ga + 9);
    issue("R3 write bank 0", C_WR, 2'd0, 1'b0, s, g);
    chk("R3 read to write turnaround", g, ga + 14);
    issue("R3 read bank 3 after write", C_RD, 2'd3, 1'b0, s, g);
    chk("R3 write to read spacing", g, ga + 18);
    issue("R6 close bank 0", C_PRE, 2'd0, 1'b0, s, g);
    issue("R6 close bank 3", C_PRE, 2'd3, 1'b0, s, g);
    repeat (20) @(negedge clk);

    // R7: auto precharge with burst of 4, AL 0
    cfg_bl8 = 1'b0;
    issue("R7 activate bank 1", C_ACT, 2'd1, 1'b0, s, ga);
    issue("R7 write with auto precharge", C_WR, 2'd1, 1'b1, s, gwr);
    chk("R2 write after activate delay", gwr, ga + 5);
    expect_hold("R7 read during auto close held", C_RD, 2'd1, 2);
    issue("R7 activate after auto close", C_ACT, 2'd1, 1'b0, s, g);
    chk("R7 activate after auto close and precharge delay", g, gwr + 2 + 5);
    issue("R7 close bank 1", C_PRE, 2'd1, 1'b0, s, g);
    repeat (20) @(negedge clk);

    // sweep of all latencies and burst lengths
    for (int bl = 0; bl < 2; bl++) begin
      for (int al = 0; al <= 6; al++) begin
        for (int cl = 3; cl <= 6; cl++) begin
          logic [1:0] bk;
          bk = 2'(al % 4);
          cfg_bl8 = bl[0]; cfg_al = 3'(al); cfg_cl = 3'(cl);
          beats = bl ? 4 : 2;
          eff = (5 > al + 1) ? 5 - al : 1;
          rl = al + cl;
          clear_windows();
          issue("R1 sweep activate", C_ACT, bk, 1'b0, s, ga);
          issue("R2 sweep read", C_RD, bk, 1'b0, s, grd);
          chk($sformatf("R2 sweep read grant al=%0d cl=%0d bl8=%0d", al, cl, bl), grd, ga + eff);
          issue("R3 sweep write", C_WR, bk, 1'b0, s, gwr);
          chk($sformatf("R3 sweep turnaround al=%0d cl=%0d bl8=%0d", al, cl, bl), gwr, grd + beats + 1);
          issue("R6 sweep precharge", C_PRE, bk, 1'b0, s, gpre);
          chk($sformatf("R6 sweep precharge al=%0d bl8=%0d", al, bl), gpre, gwr + al + beats);
          issue("R1 sweep reactivate", C_ACT, bk, 1'b0, s, gact);
          chk("R1 sweep reactivate after precharge delay", gact, gpre + 5);
          issue("R6 sweep close", C_PRE, bk, 1'b0, s, g);
          chk("R6 sweep precharge with no column", g, gact + 1);
          repeat (30) @(negedge clk);
          chk($sformatf("R4 read window start al=%0d cl=%0d", al, cl), rd_first, grd + rl);
          chk($sformatf("R4 read window length bl8=%0d", bl), rd_cnt, beats);
          chk("R4 read window contiguous", rd_last - rd_first + 1, beats);
          chk($sformatf("R5 write window start al=%0d cl=%0d", al, cl), wr_first, gwr + rl - 1);
          chk($sformatf("R5 write window length bl8=%0d", bl), wr_cnt, beats);
          chk("R5 write window contiguous", wr_last - wr_first + 1, beats);
        end
      end
    end

    summary();
    $finish;
  end

endmodule